// File: doc/BRIEF.md
# Transmit Sample Buffer with Burst DMA Request

This block sits between a 32-bit memory-mapped register bus and an audio serializer. Software or a DMA engine writes samples to a write-only data address, and the block holds them in a small first-in first-out store. The serializer pulls them out one at a time through a valid/pop pair. A DMA request line tells the DMA engine that a burst of four words will fit, but only while software has enabled it.

A control word holds a sample-width mode and a self-clearing flush command. A counter records how many samples the serializer has taken, and software can reload it, usually with zero. A read-only status word reports fill level, free space and flags. Reads are combinational, take effect in the same cycle and have no side effects. Writes take effect at the next rising clock edge.

Top module: `txf_top`

## Requirements
- R1: After reset, the control word (0x14) reads 0x000400F0, the DMA control word (0x1C) reads 0, the sample counter (0x2C) reads 0, the status word reads empty with 16 entries free, `smp_valid` is 0 and `dma_req` is 0.
- R2: Words written to 0x0C leave on `smp_data` in the order they were written. `smp_valid` is 1 exactly while the store holds at least one entry. `smp_data` shows the oldest entry, and a pop while valid removes it at the next edge.
- R3: A data write while 16 entries are held is discarded. A pop while empty changes nothing, and the sample counter is not advanced.
- R4: Reading address 0x0C always returns 0, whatever the store holds.
- R5: When control bit 2 is 1, only bits [15:0] of a data write are stored and bits [31:16] of that entry are zero. When bit 2 is 0, the whole word is stored.
- R6: A control write with bit 25 set leaves the store empty at the next edge. A data write or pop in that same cycle is discarded and the counter is not advanced. Bits 25 and 24 always read back 0, bit 24 has no effect, bits [23:0] are stored as written and bits [31:26] read 0.
- R7: `dma_req` is 1 exactly when DMA control bit 7 is 1 and at least 4 entries are free. DMA control bit 3 is stored and read back but affects nothing. All other bits of 0x1C read 0.
- R8: The sample counter at 0x2C increments by one for each accepted pop. A write to 0x2C loads the written value, and a write of 0 clears it. When a write and a pop fall in the same cycle, the written value wins.
- R9: The status word at 0x18 has the fill level in bits [4:0], the free count in bits [12:8], `dma_req` in bit 16, empty in bit 17 and full in bit 18. All other bits read 0, and writes to 0x18 change nothing. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_waddr | input | 8 | Write byte address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 8 | Read byte address |
| bus_rdata | output | 32 | Read data, combinational from `bus_raddr` |
| smp_pop | input | 1 | Serializer takes the head sample |
| smp_data | output | 32 | Oldest held sample |
| smp_valid | output | 1 | Store holds at least one sample |
| dma_req | output | 1 | Room for a 4-word burst and request enabled |

## Verification
A serializer pop can coincide with a software write to the sample counter. A pop can also coincide with a flush command, and each such collision has a single defined winner. The bench provokes these collisions in directed cycles: a counter clear together with a valid pop, a nonzero counter load together with a pop, and a flush together with a pop while entries are held. The random phase keeps pops busy while counter and control writes arrive, so further collisions occur there. Each cycle is judged against a model that applies the stated priority: a flush discards the pop, and a counter write overrides the increment. The next cycle's counter value, fill level and head sample must match that model.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] A_DATA = 8'h0C;
    localparam logic [BUS_AW-1:0] A_CTRL = 8'h14;
    localparam logic [BUS_AW-1:0] A_STAT = 8'h18;
    localparam logic [BUS_AW-1:0] A_DMAC = 8'h1C;
    localparam logic [BUS_AW-1:0] A_SCNT = 8'h2C;

    localparam logic [BUS_DW-1:0] CTRL_RST = 32'h0004_00F0;
    localparam int CTRL_KEEP_W  = 24;
    localparam int B_FLUSH_TX   = 25;
    localparam int B_FLUSH_RX   = 24;
    localparam int B_HALF_MODE  = 2;
    localparam int B_DREQ_TX    = 7;
    localparam int B_DREQ_RX    = 3;

    localparam int ST_FREE_LSB  = 8;
    localparam int ST_REQ       = 16;
    localparam int ST_EMPTY     = 17;
    localparam int ST_FULL      = 18;
endpackage

// File: rtl/txf_ring.sv
`timescale 1ns/1ps
module txf_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          pop_ok,
    output logic [DW-1:0] head,
    output logic [LW-1:0] lvl,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [LW-1:0] lvl;
    } ring_t;

    ring_t s_d, s_q;
    logic  push_ok;
    logic [DW-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        full    = (s_q.lvl == LW'(DEPTH));
        empty   = (s_q.lvl == '0);
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        if (flush) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.lvl = '0;
        end else begin
            if (push_ok) s_d.wr = step(s_q.wr);
            if (pop_ok)  s_d.rd = step(s_q.rd);
            case ({push_ok, pop_ok})
                2'b10:   s_d.lvl = s_q.lvl + 1'b1;
                2'b01:   s_d.lvl = s_q.lvl - 1'b1;
                default: s_d.lvl = s_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[s_q.wr] <= push_data;
    end

    assign head = mem[s_q.rd];
    assign lvl  = s_q.lvl;
endmodule

// File: rtl/txf_regs.sv
`timescale 1ns/1ps
module txf_regs
    import txf_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BUS_AW-1:0] waddr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              pop_ok,
    output logic              flush_tx,
    output logic              half_mode,
    output logic              dreq_en,
    output logic [BUS_DW-1:0] ctrl_word,
    output logic [BUS_DW-1:0] dmac_word,
    output logic [CW-1:0]     scnt
);
    typedef struct packed {
        logic [CTRL_KEEP_W-1:0] ctrl;
        logic                   tx_en;
        logic                   rx_en;
        logic [CW-1:0]          cnt;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_dmac, wr_scnt;
    logic  wr_unused;

    always_comb begin
        r_d      = r_q;
        wr_ctrl  = wr && (waddr == A_CTRL);
        wr_dmac  = wr && (waddr == A_DMAC);
        wr_scnt  = wr && (waddr == A_SCNT);
        flush_tx = wr_ctrl && wdata[B_FLUSH_TX];
        if (wr_ctrl) r_d.ctrl = wdata[CTRL_KEEP_W-1:0];
        if (wr_dmac) begin
            r_d.tx_en = wdata[B_DREQ_TX];
            r_d.rx_en = wdata[B_DREQ_RX];
        end
        if (wr_scnt)     r_d.cnt = CW'(wdata);
        else if (pop_ok) r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl  <= CTRL_RST[CTRL_KEEP_W-1:0];
            r_q.tx_en <= 1'b0;
            r_q.rx_en <= 1'b0;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_unused = ^{wdata[BUS_DW-1:B_FLUSH_RX]};
    assign half_mode = r_q.ctrl[B_HALF_MODE];
    assign dreq_en   = r_q.tx_en;
    assign ctrl_word = {{(BUS_DW-CTRL_KEEP_W){1'b0}}, r_q.ctrl};
    always_comb begin
        dmac_word            = '0;
        dmac_word[B_DREQ_TX] = r_q.tx_en;
        dmac_word[B_DREQ_RX] = r_q.rx_en;
    end
    assign scnt = r_q.cnt;
endmodule

// File: rtl/txf_dreq.sv
`timescale 1ns/1ps
module txf_dreq
    import txf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0]     lvl,
    input  logic              en,
    output logic              req,
    output logic [BUS_DW-1:0] status
);
    logic [LW-1:0] room;

    always_comb begin
        room   = LW'(DEPTH) - lvl;
        req    = en && (room >= LW'(BURST));
        status = '0;
        status[LW-1:0]              = lvl;
        status[ST_FREE_LSB +: LW]   = room;
        status[ST_REQ]              = req;
        status[ST_EMPTY]            = (lvl == '0);
        status[ST_FULL]             = (lvl == LW'(DEPTH));
    end
endmodule

// File: rtl/txf_top.sv
`timescale 1ns/1ps
module txf_top
    import txf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 4,
    parameter int CNT_W = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_waddr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic [BUS_AW-1:0] bus_raddr,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              smp_pop,
    output logic [BUS_DW-1:0] smp_data,
    output logic              smp_valid,
    output logic              dma_req
);
    logic              flush_tx, half_mode, dreq_en, pop_ok, empty, full;
    logic [LW-1:0]     lvl;
    logic [BUS_DW-1:0] ctrl_word, dmac_word, status, push_data;
    logic [CNT_W-1:0]  scnt;
    logic              push;

    assign push      = bus_wr && (bus_waddr == A_DATA);
    assign push_data = half_mode ? {16'h0000, bus_wdata[15:0]} : bus_wdata;

    txf_ring #(.DEPTH(DEPTH), .DW(BUS_DW)) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx), .push(push),
        .push_data(push_data), .pop(smp_pop), .pop_ok(pop_ok),
        .head(smp_data), .lvl(lvl), .empty(empty), .full(full)
    );

    txf_regs #(.CW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .waddr(bus_waddr),
        .wdata(bus_wdata), .pop_ok(pop_ok), .flush_tx(flush_tx),
        .half_mode(half_mode), .dreq_en(dreq_en), .ctrl_word(ctrl_word),
        .dmac_word(dmac_word), .scnt(scnt)
    );

    txf_dreq #(.DEPTH(DEPTH), .BURST(BURST)) u_dreq (
        .lvl(lvl), .en(dreq_en), .req(dma_req), .status(status)
    );

    assign smp_valid = !empty;

    always_comb begin
        case (bus_raddr)
            A_CTRL:  bus_rdata = ctrl_word;
            A_STAT:  bus_rdata = status;
            A_DMAC:  bus_rdata = dmac_word;
            A_SCNT:  bus_rdata = BUS_DW'(scnt);
            default: bus_rdata = '0;
        endcase
    end

    logic full_unused;
    assign full_unused = full;
endmodule

// File: rtl/txf_chk.sv
`timescale 1ns/1ps
module txf_chk
    import txf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 4,
    parameter int CW    = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_waddr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [BUS_AW-1:0] bus_raddr,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic              smp_valid,
    input logic              dma_req,
    input logic              pop_ok,
    input logic [LW-1:0]     lvl,
    input logic [CW-1:0]     scnt
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LW'(DEPTH));
    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_waddr == A_CTRL && bus_wdata[B_FLUSH_TX]) |=> (lvl == '0));
    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_waddr == A_SCNT) |=> (scnt == $past(bus_wdata[CW-1:0])));
    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !(bus_wr && bus_waddr == A_SCNT)) |=> (scnt == $past(scnt) + 1'b1));
    // R7
    dreq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl > LW'(DEPTH - BURST)) |-> !dma_req);
    // R2
    valid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid == (lvl != '0));
    // R4
    data_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_raddr == A_DATA) |-> (bus_rdata == '0));
endmodule

bind txf_top txf_chk #(.DEPTH(DEPTH), .BURST(BURST), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .smp_valid(smp_valid), .dma_req(dma_req), .pop_ok(pop_ok),
    .lvl(lvl), .scnt(scnt)
);

// File: tb/sim_txf_top.sv
`timescale 1ns/1ps
module sim_txf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_waddr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [7:0]  bus_raddr = 8'h0;
    logic [31:0] bus_rdata;
    logic        smp_pop = 1'b0;
    logic [31:0] smp_data;
    logic        smp_valid;
    logic        dma_req;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] q[$];
    logic [31:0] m_ctrl = 32'h0004_00F0;
    logic [31:0] m_dmac = 32'h0;
    logic [31:0] m_cnt  = 32'h0;

    always #2.5 clk = ~clk;

    txf_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .smp_pop(smp_pop), .smp_data(smp_data), .smp_valid(smp_valid),
        .dma_req(dma_req)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    function automatic logic exp_req();
        return m_dmac[7] && ((16 - q.size()) >= 4);
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] s = 32'h0;
        s[4:0]  = 5'(q.size());
        s[12:8] = 5'(16 - q.size());
        s[16]   = exp_req();
        s[17]   = (q.size() == 0);
        s[18]   = (q.size() == 16);
        return s;
    endfunction

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_raddr = a;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic check_state();
        logic [31:0] v;
        chk("R2 valid", 32'(smp_valid), 32'(q.size() > 0));
        if (q.size() > 0) chk("R2 head", smp_data, q[0]);
        chk("R7 dma_req", 32'(dma_req), 32'(exp_req()));
        rd(8'h18, v); chk("R9 status", v, exp_status());
        rd(8'h2C, v); chk("R8 counter", v, m_cnt);
        rd(8'h14, v); chk("R6 ctrl readback", v, m_ctrl);
        rd(8'h1C, v); chk("R7 dmac readback", v, m_dmac);
        rd(8'h0C, v); chk("R4 data reads zero", v, 32'h0);
    endtask

    // one bus/pop cycle: drive, update model, clock, then compare
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic pop);
        logic flush;
        logic pop_ok;
        int   sz;
        bus_wr = wr; bus_waddr = a; bus_wdata = d; smp_pop = pop;
        flush  = wr && a == 8'h14 && d[25];
        sz     = q.size();
        pop_ok = pop && sz > 0 && !flush;
        if (flush) q.delete();
        else begin
            if (pop_ok) void'(q.pop_front());
            if (wr && a == 8'h0C && sz < 16)
                q.push_back(m_ctrl[2] ? {16'h0, d[15:0]} : d);
        end
        if (wr && a == 8'h2C) m_cnt = d;
        else if (pop_ok)      m_cnt = m_cnt + 1;
        if (wr && a == 8'h14) m_ctrl = d & 32'h00FF_FFFF;
        if (wr && a == 8'h1C) m_dmac = d & 32'h0000_0088;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; smp_pop = 1'b0;
        check_state();
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h14, v); chk("R1 ctrl reset", v, 32'h0004_00F0);
        rd(8'h1C, v); chk("R1 dmac reset", v, 32'h0);
        rd(8'h2C, v); chk("R1 counter reset", v, 32'h0);
        chk("R1 valid reset", 32'(smp_valid), 32'h0);
        chk("R1 dma_req reset", 32'(dma_req), 32'h0);
        check_state();
        // R3 pop on empty leaves counter alone
        cyc(1'b0, 8'h0, 32'h0, 1'b1);
        // R2 R3 fill past 16 in full-word mode
        for (int i = 0; i < 20; i++) cyc(1'b1, 8'h0C, 32'hA500_0000 + 32'(i * 7919), 1'b0);
        // R7 enable request: full, no request
        cyc(1'b1, 8'h1C, 32'hFFFF_FFFF, 1'b0);
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'h0, 32'h0, 1'b1);
        // R7 rx enable only: no request
        cyc(1'b1, 8'h1C, 32'h0000_0008, 1'b0);
        // R8 pop with counter clear, then pop with nonzero load
        cyc(1'b1, 8'h2C, 32'h0, 1'b1);
        cyc(1'b1, 8'h2C, 32'h1234_5678, 1'b1);
        // R9 write to status ignored
        cyc(1'b1, 8'h18, 32'hFFFF_FFFF, 1'b0);
        // R6 bit 24 alone has no effect, then flush with a pop
        cyc(1'b1, 8'h14, 32'h0104_00F0, 1'b0);
        cyc(1'b1, 8'h14, 32'h0204_00F0, 1'b1);
        // R5 half-word mode
        cyc(1'b1, 8'h14, 32'h0004_00F4, 1'b0);
        cyc(1'b1, 8'h0C, 32'hDEAD_BEEF, 1'b0);
        cyc(1'b1, 8'h14, 32'h0004_00F0, 1'b0);
        cyc(1'b1, 8'h0C, 32'hCAFE_F00D, 1'b0);
        cyc(1'b1, 8'h1C, 32'h0000_0080, 1'b0);
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int sel = int'($urandom % 20);
            int bias = ((i / 500) % 2 == 0) ? 30 : 70;
            logic w = ($urandom % 100) < 60;
            logic [7:0] a;
            logic [31:0] d = $urandom;
            if (sel < 12 || sel > 16) a = 8'h0C;
            else if (sel == 12) begin a = 8'h14; if ($urandom % 4 != 0) d[25] = 1'b0; end
            else if (sel == 13) a = 8'h1C;
            else if (sel == 14) begin a = 8'h2C; if ($urandom % 2 == 0) d = 32'h0; end
            else a = 8'h18;
            cyc(w, a, d, ($urandom % 100) < bias);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule